// File: doc/BRIEF.md
# Real-Time Clock Core with Trim Divider and Alarm

The block keeps time as a seconds count. A free-running prescaler divides the system clock by a fixed amount. Each wrap of the prescaler produces one sub-tick. A programmable trim divider then counts sub-ticks until it reaches a software-set limit. Each time the trim divider reaches that limit, the seconds counter advances by one. Software tunes the length of a second by choosing the trim limit.

The block can signal two events:
- **Alarm.** When a second elapses, the count that was held before the increment is compared against an alarm value.
- **Per-second event.** This occurs on every second.

Each event sets a sticky flag in a small status register, but only when that event's enable bit is set. Each flag drives its own interrupt line while its enable bit stays set. Software clears a flag by writing one to it.

Software can load the trim limit, the alarm value, the seconds counter and the status register through separate write strobes. The counter and the status register can be read back on output ports.

Top module: `rtc_trim_core`

## Requirements
- R1: The prescaler counts 0 to SCALE and then wraps. With a constant trim limit T, the seconds counter advances exactly once every (SCALE+1)*(T+1) clocks.
- R2: On each sub-tick, the trim count is compared with the trim limit. If they are equal, the trim count returns to 0. Otherwise it increments. The trim limit resets to 0, so after reset every sub-tick is a second.
- R3: On each trim match, the seconds counter increments by one, wrapping modulo 2^32. Without a match or a write, it holds its value.
- R4: On a trim match, status bit 0 (alarm flag) is set when two conditions hold: the count before the increment equals the alarm value, and status bit 2 (alarm enable) is 1. If the enable is 0, the flag is not set.
- R5: On every trim match, status bit 1 (second flag) is set if status bit 3 (second enable) is 1.
- R6: `irq_alarm_o` equals status bit 0 AND bit 2. `irq_sec_o` equals status bit 1 AND bit 3.
- R7: A status write with a one in bit 0 or bit 1 clears that flag. If a flag is set and cleared in the same cycle, the set wins.
- R8: A status write loads bits 2 and 3 directly. `stat_o[3:0]` reads back all four status bits, one clock after the write.
- R9: A counter write loads the counter on the next edge. It takes priority over an increment in the same cycle.
- R10: After reset, the counter, alarm value, trim limit and status all read zero, and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trim_we_i | input | 1 | Trim limit write strobe |
| trim_wdata_i | input | 16 | Trim limit write data |
| alarm_we_i | input | 1 | Alarm value write strobe |
| alarm_wdata_i | input | 32 | Alarm value write data |
| cnt_we_i | input | 1 | Seconds counter write strobe |
| cnt_wdata_i | input | 32 | Seconds counter write data |
| stat_we_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 4 | Status write data (bits 0-1 clear on one, bits 2-3 enables) |
| cnt_o | output | 32 | Seconds counter readback |
| stat_o | output | 4 | Status readback |
| irq_alarm_o | output | 1 | Alarm interrupt |
| irq_sec_o | output | 1 | Per-second interrupt |

## Verification
Two pairs of functions can fall in the same cycle:
- a software counter write and a trim-match increment;
- a write-one-to-clear of the second flag and the hardware setting that same flag.

The bench uses its own model of the prescaler and trim phase to find the cycle whose edge will produce a match. In that cycle it issues the write. It then checks two things: that the written counter value replaces the incremented one, and that the flag survives the clear. Random traffic adds further collisions, each judged against the bench model every cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned STAT_W     = 4;
  localparam int unsigned ST_ALM_FLG = 0;
  localparam int unsigned ST_SEC_FLG = 1;
  localparam int unsigned ST_ALM_EN  = 2;
  localparam int unsigned ST_SEC_EN  = 3;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned SCALE = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sub_tick_o
);
  localparam int unsigned PW = (SCALE < 2) ? 1 : $clog2(SCALE + 1);
  localparam logic [PW-1:0] TOP = PW'(SCALE);

  logic [PW-1:0] pre_q;

  assign sub_tick_o = (pre_q == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pre_q <= '0;
    else if (sub_tick_o) pre_q <= '0;
    else                 pre_q <= pre_q + 1'b1;
  end

  a_r1_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= TOP);
  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_tick_o |=> pre_q == '0);
endmodule

// File: rtl/rtc_trim_div.sv
module rtc_trim_div #(
  parameter int unsigned TRIM_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sub_tick_i,
  input  logic              trim_we_i,
  input  logic [TRIM_W-1:0] trim_wdata_i,
  output logic              sec_tick_o
);
  logic [TRIM_W-1:0] limit_q, tcnt_q;
  logic              hit;

  assign hit        = (tcnt_q == limit_q);
  assign sec_tick_o = sub_tick_i && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_q <= '0;
      tcnt_q  <= '0;
    end else begin
      if (trim_we_i) limit_q <= trim_wdata_i;
      if (sub_tick_i) tcnt_q <= hit ? '0 : tcnt_q + 1'b1;
    end
  end

  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> tcnt_q == '0);
  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sub_tick_i |=> $stable(tcnt_q));
endmodule

// File: rtl/rtc_event_regs.sv
module rtc_event_regs
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_alarm_i,
  input  logic              set_sec_i,
  input  logic              stat_we_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_alarm_o,
  output logic              irq_sec_o
);
  logic [STAT_W-1:0] stat_q;
  logic              alm_flg_d, sec_flg_d;

  always_comb begin
    alm_flg_d = stat_q[ST_ALM_FLG];
    sec_flg_d = stat_q[ST_SEC_FLG];
    if (stat_we_i && stat_wdata_i[ST_ALM_FLG]) alm_flg_d = 1'b0;
    if (stat_we_i && stat_wdata_i[ST_SEC_FLG]) sec_flg_d = 1'b0;
    // hardware set beats software clear
    if (set_alarm_i && stat_q[ST_ALM_EN]) alm_flg_d = 1'b1;
    if (set_sec_i && stat_q[ST_SEC_EN])   sec_flg_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else begin
      stat_q[ST_ALM_FLG] <= alm_flg_d;
      stat_q[ST_SEC_FLG] <= sec_flg_d;
      if (stat_we_i) begin
        stat_q[ST_ALM_EN] <= stat_wdata_i[ST_ALM_EN];
        stat_q[ST_SEC_EN] <= stat_wdata_i[ST_SEC_EN];
      end
    end
  end

  assign stat_o      = stat_q;
  assign irq_alarm_o = stat_q[ST_ALM_FLG] & stat_q[ST_ALM_EN];
  assign irq_sec_o   = stat_q[ST_SEC_FLG] & stat_q[ST_SEC_EN];

  a_r7_clear_alarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && stat_wdata_i[ST_ALM_FLG] && !set_alarm_i) |=> !stat_o[ST_ALM_FLG]);
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_sec_i && stat_o[ST_SEC_EN]) |=> stat_o[ST_SEC_FLG]);
  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[ST_ALM_FLG] && !(stat_we_i && stat_wdata_i[ST_ALM_FLG])) |=> stat_o[ST_ALM_FLG]);
  a_r4_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_o[ST_ALM_FLG] && !stat_o[ST_ALM_EN]) |=> !stat_o[ST_ALM_FLG]);
  a_r8_enable_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_i |=> stat_o[ST_SEC_EN:ST_ALM_EN] == $past(stat_wdata_i[ST_SEC_EN:ST_ALM_EN]));
endmodule

// File: rtl/rtc_trim_core.sv
module rtc_trim_core
  import rtc_pkg::*;
#(
  parameter int unsigned SCALE  = 3,
  parameter int unsigned TRIM_W = 16,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trim_we_i,
  input  logic [TRIM_W-1:0] trim_wdata_i,
  input  logic              alarm_we_i,
  input  logic [CNT_W-1:0]  alarm_wdata_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              stat_we_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_alarm_o,
  output logic              irq_sec_o
);
  logic             sub_tick, sec_tick, alarm_hit;
  logic [CNT_W-1:0] cnt_q, alarm_q;

  rtc_prescaler #(.SCALE(SCALE)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sub_tick_o (sub_tick)
  );

  rtc_trim_div #(.TRIM_W(TRIM_W)) u_trim (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sub_tick_i   (sub_tick),
    .trim_we_i    (trim_we_i),
    .trim_wdata_i (trim_wdata_i),
    .sec_tick_o   (sec_tick)
  );

  // compare uses the count held before this second's increment
  assign alarm_hit = sec_tick && (cnt_q == alarm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      alarm_q <= '0;
    end else begin
      if (alarm_we_i)    alarm_q <= alarm_wdata_i;
      if (cnt_we_i)      cnt_q   <= cnt_wdata_i;
      else if (sec_tick) cnt_q   <= cnt_q + 1'b1;
    end
  end

  rtc_event_regs u_evt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_alarm_i  (alarm_hit),
    .set_sec_i    (sec_tick),
    .stat_we_i    (stat_we_i),
    .stat_wdata_i (stat_wdata_i),
    .stat_o       (stat_o),
    .irq_alarm_o  (irq_alarm_o),
    .irq_sec_o    (irq_sec_o)
  );

  assign cnt_o = cnt_q;

  a_r9_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_o == $past(cnt_wdata_i));
  a_r3_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick && !cnt_we_i) |=> cnt_o == $past(cnt_o) + 1'b1);
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_tick && !cnt_we_i) |=> $stable(cnt_o));
endmodule

// File: tb/sim_rtc_trim_core.sv
module sim_rtc_trim_core;
  localparam int unsigned SCALE = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        trim_we = 0, alarm_we = 0, cnt_we = 0, stat_we = 0;
  logic [15:0] trim_wd = '0;
  logic [31:0] alarm_wd = '0, cnt_wd = '0;
  logic [3:0]  stat_wd = '0;
  logic [31:0] cnt;
  logic [3:0]  stat;
  logic        irq_a, irq_s;

  int n_run = 0, n_fail = 0;

  // reference state
  int unsigned m_pre = 0;
  logic [15:0] m_trim = '0, m_tc = '0;
  logic [31:0] m_cnt = '0, m_alarm = '0;
  logic [3:0]  m_stat = '0;

  always #5 clk = ~clk;

  rtc_trim_core #(.SCALE(SCALE)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .trim_we_i(trim_we), .trim_wdata_i(trim_wd),
    .alarm_we_i(alarm_we), .alarm_wdata_i(alarm_wd),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wd),
    .stat_we_i(stat_we), .stat_wdata_i(stat_wd),
    .cnt_o(cnt), .stat_o(stat), .irq_alarm_o(irq_a), .irq_sec_o(irq_s)
  );

  function automatic logic match_next();
    return (m_pre == SCALE) && (m_tc == m_trim);
  endfunction

  function automatic logic [3:0] next_stat(logic [3:0] s, logic we, logic [3:0] wd,
                                           logic sa, logic ss);
    logic [3:0] r;
    r = s;
    if (we) begin
      r[3:2] = wd[3:2];
      r[1:0] = s[1:0] & ~wd[1:0];
    end
    if (sa && s[2]) r[0] = 1'b1;
    if (ss && s[3]) r[1] = 1'b1;
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    logic tk, mt;
    @(posedge clk);
    tk = (m_pre == SCALE);
    mt = tk && (m_tc == m_trim);
    m_pre = tk ? 0 : m_pre + 1;
    if (tk) m_tc = mt ? '0 : m_tc + 1'b1;
    m_stat = next_stat(m_stat, stat_we, stat_wd, mt && (m_cnt == m_alarm), mt);
    if (cnt_we)   m_cnt = cnt_wd;
    else if (mt)  m_cnt = m_cnt + 1;
    if (alarm_we) m_alarm = alarm_wd;
    if (trim_we)  m_trim = trim_wd;
    @(negedge clk);
    trim_we = 0; alarm_we = 0; cnt_we = 0; stat_we = 0;
    check("R3 counter", cnt, m_cnt);
    check("R7 status", {28'd0, stat}, {28'd0, m_stat});
    check("R6 irq_alarm", {31'd0, irq_a}, {31'd0, m_stat[0] & m_stat[2]});
    check("R6 irq_sec", {31'd0, irq_s}, {31'd0, m_stat[1] & m_stat[3]});
  endtask

  task automatic run_to_match();
    for (int i = 0; i < 400000 && !match_next(); i++) step();
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int t0, per;
    logic [31:0] c0;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 cnt", cnt, 0);
    check("R10 stat", {28'd0, stat}, 0);
    check("R10 irqs", {30'd0, irq_a, irq_s}, 0);
    rst_n = 1'b1;

    // R2 trim limit 0 after reset: one second per sub-tick
    c0 = m_cnt;
    repeat (4 * (SCALE + 1)) step();
    check("R2 default trim", cnt, c0 + 4);

    // R1 period with trim = m_tc + 2 (limit above current count)
    trim_wd = m_tc + 16'd2; trim_we = 1; step();
    run_to_match(); step();
    c0 = cnt; t0 = 0;
    while (cnt == c0 && t0 < 1000) begin step(); t0++; end
    per = (SCALE + 1) * (m_trim + 1);
    check("R1 period", t0, per);

    // R8 enables load and read back
    stat_wd = 4'b1000; stat_we = 1; step();
    check("R8 enable readback", {28'd0, stat[3:2]}, 32'd2);

    // R5 second flag on match
    run_to_match(); step();
    check("R5 sec flag", {31'd0, stat[1]}, 1);
    check("R6 irq_sec", {31'd0, irq_s}, 1);

    // R7 W1C clears, enable kept
    stat_wd = 4'b1010; stat_we = 1; step();
    check("R7 clear", {28'd0, stat}, 32'h8);

    // R4 alarm with enable off: no flag
    alarm_wd = m_cnt; alarm_we = 1; step();
    run_to_match(); step();
    check("R4 disabled alarm", {31'd0, stat[0]}, 0);

    // R4 alarm with enable on
    stat_wd = 4'b1110; stat_we = 1; step();
    alarm_wd = m_cnt; alarm_we = 1; step();
    run_to_match(); step();
    check("R4 alarm flag", {31'd0, stat[0]}, 1);
    check("R6 irq_alarm", {31'd0, irq_a}, 1);

    // R9 counter write collides with increment
    run_to_match();
    cnt_wd = 32'hFFFF_FFF0; cnt_we = 1; step();
    check("R9 write wins", cnt, 32'hFFFF_FFF0);

    // R7 clear and set in the same cycle: set wins
    run_to_match();
    stat_wd = 4'b1110; stat_we = 1; step();
    check("R7 set beats clear", {31'd0, stat[1]}, 1);

    // R3 wrap through 2^32
    cnt_wd = 32'hFFFF_FFFF; cnt_we = 1; step();
    run_to_match(); step();
    check("R3 wrap", cnt, 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom_range(0, 99);
      if (r < 4) begin stat_we = 1; stat_wd = 4'($urandom); end
      else if (r < 6) begin cnt_we = 1; cnt_wd = $urandom_range(0, 7); end
      else if (r < 8) begin alarm_we = 1; alarm_wd = m_cnt + $urandom_range(0, 3); end
      else if (r < 9) begin trim_we = 1; trim_wd = m_tc + 16'($urandom_range(0, 3)); end
      step();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule